// File: doc/BRIEF.md
# Interleaved Multi-Stream Accumulate-and-Mix Recurrence

This block runs one loop-carried recurrence for `SLOWS` independent data streams on a single piece of hardware. Each stream keeps a word of state. A valid sample folds into the state as `next = rotl(state + sample, ROT) ^ SALT`. Arithmetic is modulo 2^WIDTH, and `rotl` is a left rotation by `ROT % WIDTH` bits. The single feedback register of a one-stream version becomes a ring of exactly `SLOWS` registers that shifts every clock. The state of a given stream therefore arrives back at the head of the ring exactly when that stream's next slot comes round. No multiplexer selects state by stream.

Streams are served in a fixed rotation, one slot per clock: 0, 1, …, SLOWS-1, then 0 again. A free-running slot counter sets the rotation, and it starts at slot 0 on the first clock after reset. The external interleaver must present each sample with the index of the slot it belongs to. The output carries the updated state together with the slot index. When `SLOWS >= 2` and `SPLIT_MIX` is set, the extra ring registers split the loop into an add stage and a rotate-and-salt stage, which shortens the critical path. Each sample still produces one result, but a given stream can issue a new sample only once every `SLOWS` clocks.

Top module: `cslow_mix_core`

## Requirements
- R1: For an accepted sample x in slot k, the output one result later is `out_data = rotl(s_k + x, ROT) ^ SALT` (default ROT=3, SALT=16'h5A3C, WIDTH=16), with `out_valid` high, where s_k is the stored state of stream k. That result also becomes the new s_k.
- R2: The streams are fully independent. Each stream's sequence of results equals that of a separate single-stream accumulator fed only that stream's samples, and the state ring holds exactly SLOWS words.
- R3: After reset the slot counter starts at 0 and advances by one modulo SLOWS on every clock. `out_stream` always shows the slot of the sample whose result is on `out_data`, and it stays below SLOWS.
- R4: When `in_valid` is low in a slot, that stream's state passes through unchanged and `out_valid` is low for the matching output.
- R5: A sample with `in_valid` high but `in_stream` different from the current slot is ignored, exactly as in R4.
- R6: The output follows the input by 1 clock in the fused variant, and by 2 clocks when SPLIT_MIX=1 and SLOWS>=2. With SLOWS=1, SPLIT_MIX falls back to the fused variant.
- R7: A synchronous reset clears every ring register, the slot counter and the output, so the output reads `out_valid`=0, `out_data`=0 and `out_stream`=0. After reset, every stream starts again from state 0.
- R8: The addition wraps modulo 2^WIDTH; a sample of all ones produces no carry-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present in this slot |
| in_stream | input | SW | Slot index claimed by the sample (SW = max(1, clog2(SLOWS))) |
| in_data | input | WIDTH | Sample value |
| out_valid | output | 1 | Result present |
| out_stream | output | SW | Slot index of the result |
| out_data | output | WIDTH | Updated stream state |

## Verification
The bench builds four copies side by side, with SLOWS = 1, 2, 3 and 4. SLOWS=2 and SLOWS=4 use the split variant, SLOWS=3 uses the fused variant, and SLOWS=1 requests neither. This covers both latencies, a ring with no pass-through stages, an odd-length ring, and the degenerate single-stream loop. Because these configurations are small, every slot of every copy can be driven through dense, sparse, mismatched-index, all-ones and mid-run-reset phases. Each copy is compared on every clock against one arithmetic model per stream.

// File: rtl/cslow_pkg.sv
package cslow_pkg;

    typedef enum logic {
        MIX_FUSED = 1'b0,
        MIX_SPLIT = 1'b1
    } mix_variant_e;

    // width of a slot index; at least one bit even for a single stream
    function automatic int unsigned slot_bits(input int unsigned slots);
        return (slots > 1) ? $clog2(slots) : 1;
    endfunction

    // clocks from an accepted sample to its result on the output
    function automatic int unsigned loop_latency(input int unsigned slots, input bit split);
        return (split && slots >= 2) ? 2 : 1;
    endfunction

endpackage

// File: rtl/cslow_slot_counter.sv
module cslow_slot_counter #(
    parameter int unsigned SLOWS = 4,
    parameter int unsigned SW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [SW-1:0] in_stream,
    output logic [SW-1:0] slot,
    output logic          take
);
    localparam logic [SW-1:0] LAST = SW'(SLOWS - 1);

    typedef struct packed {
        logic [SW-1:0] slot;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d      = cnt_q;
        cnt_d.slot = (cnt_q.slot == LAST) ? '0 : cnt_q.slot + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign slot = cnt_q.slot;
    // a sample only counts when it claims the slot now being served
    assign take = in_valid && (in_stream == cnt_q.slot);

endmodule

// File: rtl/cslow_mix_unit.sv
module cslow_mix_unit #(
    parameter int unsigned      WIDTH = 16,
    parameter int unsigned      ROT   = 3,
    parameter logic [WIDTH-1:0] SALT  = 'h5A3C
) (
    input  logic [WIDTH-1:0] state_i,
    input  logic [WIDTH-1:0] sample_i,
    input  logic             take_i,
    output logic [WIDTH-1:0] sum_o,
    input  logic [WIDTH-1:0] scr_i,
    output logic [WIDTH-1:0] scr_o
);
    localparam int unsigned RS = ROT % WIDTH;

    always_comb begin
        sum_o = take_i ? state_i + sample_i : state_i;
        if (RS == 0) scr_o = scr_i ^ SALT;
        else         scr_o = ((scr_i << RS) | (scr_i >> (WIDTH - RS))) ^ SALT;
    end

endmodule

// File: rtl/cslow_delay_line.sv
module cslow_delay_line #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [DEPTH-1:0][WIDTH-1:0] line_d, line_q;

    // every stage shifts on every clock: no enable, so slots never slip
    always_comb begin
        line_d[0] = din;
        for (int i = 1; i < DEPTH; i++) line_d[i] = line_q[i-1];
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line_d;
    end

    assign dout = line_q[DEPTH-1];

endmodule

// File: rtl/cslow_mix_core.sv
module cslow_mix_core
    import cslow_pkg::*;
#(
    parameter int unsigned      SLOWS     = 4,
    parameter int unsigned      WIDTH     = 16,
    parameter int unsigned      ROT       = 3,
    parameter logic [WIDTH-1:0] SALT      = 'h5A3C,
    parameter bit               SPLIT_MIX = 1'b1,
    localparam int unsigned     SW        = slot_bits(SLOWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SW-1:0]    in_stream,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    output logic [SW-1:0]    out_stream,
    output logic [WIDTH-1:0] out_data
);
    localparam mix_variant_e VARIANT    = (SPLIT_MIX && SLOWS >= 2) ? MIX_SPLIT : MIX_FUSED;
    localparam int unsigned  OWN_STAGES = (VARIANT == MIX_SPLIT) ? 2 : 1;
    localparam int unsigned  REST       = SLOWS - OWN_STAGES;

    logic [SW-1:0]    slot;
    logic             take;
    logic [WIDTH-1:0] tail;
    logic [WIDTH-1:0] head;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] scr_in;
    logic [WIDTH-1:0] scr_out;

    cslow_slot_counter #(
        .SLOWS (SLOWS),
        .SW    (SW)
    ) u_slots (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_stream (in_stream),
        .slot      (slot),
        .take      (take)
    );

    cslow_mix_unit #(
        .WIDTH (WIDTH),
        .ROT   (ROT),
        .SALT  (SALT)
    ) u_mix (
        .state_i  (tail),
        .sample_i (in_data),
        .take_i   (take),
        .sum_o    (sum),
        .scr_i    (scr_in),
        .scr_o    (scr_out)
    );

    if (VARIANT == MIX_SPLIT) begin : g_split
        // ring slot 0 holds the sum, ring slot 1 the finished state
        typedef struct packed {
            logic [WIDTH-1:0] acc;
            logic             mix;
            logic [SW-1:0]    sid_a;
            logic [WIDTH-1:0] st;
            logic             vld;
            logic [SW-1:0]    sid;
        } split_s;

        split_s s_d, s_q;

        assign scr_in = s_q.acc;

        always_comb begin
            s_d       = s_q;
            s_d.acc   = sum;
            s_d.mix   = take;
            s_d.sid_a = slot;
            s_d.st    = s_q.mix ? scr_out : s_q.acc;
            s_d.vld   = s_q.mix;
            s_d.sid   = s_q.sid_a;
        end

        always_ff @(posedge clk) begin
            if (rst) s_q <= '0;
            else     s_q <= s_d;
        end

        assign head       = s_q.st;
        assign out_valid  = s_q.vld;
        assign out_stream = s_q.sid;
    end else begin : g_fused
        typedef struct packed {
            logic [WIDTH-1:0] st;
            logic             vld;
            logic [SW-1:0]    sid;
        } fused_s;

        fused_s f_d, f_q;

        assign scr_in = sum;

        always_comb begin
            f_d     = f_q;
            f_d.st  = take ? scr_out : tail;
            f_d.vld = take;
            f_d.sid = slot;
        end

        always_ff @(posedge clk) begin
            if (rst) f_q <= '0;
            else     f_q <= f_d;
        end

        assign head       = f_q.st;
        assign out_valid  = f_q.vld;
        assign out_stream = f_q.sid;
    end

    if (REST > 0) begin : g_ring
        cslow_delay_line #(
            .WIDTH (WIDTH),
            .DEPTH (REST)
        ) u_ring (
            .clk  (clk),
            .rst  (rst),
            .din  (head),
            .dout (tail)
        );
    end else begin : g_short
        assign tail = head;
    end

    assign out_data = head;

endmodule

// File: rtl/cslow_mix_checker.sv
module cslow_mix_checker
    import cslow_pkg::*;
#(
    parameter int unsigned  SLOWS     = 4,
    parameter int unsigned  WIDTH     = 16,
    parameter bit           SPLIT_MIX = 1'b1,
    localparam int unsigned SW        = slot_bits(SLOWS)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [SW-1:0]    in_stream,
    input logic             out_valid,
    input logic [SW-1:0]    out_stream,
    input logic [WIDTH-1:0] out_data
);
    localparam int unsigned   LAT  = loop_latency(SLOWS, SPLIT_MIX);
    localparam logic [SW-1:0] LAST = SW'(SLOWS - 1);

    logic [1:0] warm_q;

    always_ff @(posedge clk) begin
        if (rst)                 warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    p_stream_range_r3: assert property (@(posedge clk) disable iff (rst)
        out_stream <= LAST);

    p_stream_step_r3: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |=>
            out_stream == (($past(out_stream) == LAST) ? '0 : $past(out_stream) + 1'b1));

    // R4 as well: a result only follows a valid sample claiming its own slot
    if (LAT == 1) begin : g_lat1
        p_valid_source_r5: assert property (@(posedge clk) disable iff (rst)
            (warm_q == 2'd3 && out_valid) |->
                ($past(in_valid) && $past(in_stream) == out_stream));
    end else begin : g_lat2
        p_valid_source_r5: assert property (@(posedge clk) disable iff (rst)
            (warm_q == 2'd3 && out_valid) |->
                ($past(in_valid, 2) && $past(in_stream, 2) == out_stream));
    end

    p_reset_clear_r7: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_data == '0 && out_stream == '0));

endmodule

bind cslow_mix_core cslow_mix_checker #(
    .SLOWS     (SLOWS),
    .WIDTH     (WIDTH),
    .SPLIT_MIX (SPLIT_MIX)
) u_check (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_stream  (in_stream),
    .out_valid  (out_valid),
    .out_stream (out_stream),
    .out_data   (out_data)
);

// File: tb/sim_cslow_mix_core.sv
module sim_cslow_mix_core;

    logic clk = 1'b0;
    always #2ns clk = ~clk;

    int       errors = 0;
    int       checks = 0;
    bit [3:0] done   = '0;
    bit       closed = 1'b0;

    task automatic check(input bit ok, input string tag, input int c,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (C=%0d): actual=%0h expected=%0h", tag, c, act, exp);
        end
    endtask

    // bench model of one step: add, rotate left by 3, xor salt
    function automatic logic [15:0] ref_next(input logic [15:0] s, input logic [15:0] x);
        logic [15:0] t;
        t = s + x;
        return {t[12:0], t[15:13]} ^ 16'h5A3C;
    endfunction

    for (genvar g = 0; g < 4; g++) begin : g_dut
        localparam int unsigned C   = g + 1;
        localparam bit          SPL = (g == 1 || g == 3);
        localparam int unsigned L   = (SPL && C >= 2) ? 2 : 1;
        localparam int unsigned SW  = (C > 1) ? $clog2(C) : 1;

        logic          rst_i, v_i, ov;
        logic [SW-1:0] s_i, os;
        logic [15:0]   d_i, od;

        cslow_mix_core #(
            .SLOWS     (C),
            .WIDTH     (16),
            .ROT       (3),
            .SALT      (16'h5A3C),
            .SPLIT_MIX (SPL)
        ) u0 (
            .clk        (clk),
            .rst        (rst_i),
            .in_valid   (v_i),
            .in_stream  (s_i),
            .in_data    (d_i),
            .out_valid  (ov),
            .out_stream (os),
            .out_data   (od)
        );

        logic [15:0] model [4];
        bit          pv [2];
        logic [15:0] pd [2];
        int          ps [2];
        bit          pk [2];
        int          slot;

        // mode 0: valid sample for this slot, 1: idle slot, 2: valid but wrong index
        task automatic step(input int mode, input logic [15:0] x, input string tag);
            int sid;
            @(negedge clk);
            if (pk[L-1]) begin
                check(ov == pv[L-1], tag, C, 32'(ov), 32'(pv[L-1]));
                if (pv[L-1]) check(od == pd[L-1], tag, C, 32'(od), 32'(pd[L-1]));
                check(int'(os) == ps[L-1], "R3", C, 32'(os), 32'(ps[L-1]));
            end
            pv[1] = pv[0]; pd[1] = pd[0]; ps[1] = ps[0]; pk[1] = pk[0];
            sid = (mode == 2) ? (slot + 1) % ((C == 1) ? 2 : C) : slot;
            v_i = (mode != 1);
            s_i = SW'(sid);
            d_i = x;
            if (mode == 0) model[slot] = ref_next(model[slot], x);
            pv[0] = (mode == 0);
            pd[0] = model[slot];
            ps[0] = slot;
            pk[0] = 1'b1;
            slot  = (slot + 1) % C;
        endtask

        task automatic do_reset(input string tag);
            @(negedge clk);
            rst_i = 1'b1; v_i = 1'b0; s_i = '0; d_i = '0;
            repeat (2) @(negedge clk);
            check(ov == 1'b0, tag, C, 32'(ov), 32'd0);
            check(od == 16'd0, tag, C, 32'(od), 32'd0);
            check(os == '0, tag, C, 32'(os), 32'd0);
            rst_i = 1'b0;
            for (int k = 0; k < 4; k++) model[k] = '0;
            // first clock after reset serves slot 0 with the idle input above
            pk[1] = 1'b0;
            pv[0] = 1'b0; pd[0] = '0; ps[0] = 0; pk[0] = 1'b1;
            slot  = 1 % C;
        endtask

        initial begin
            rst_i = 1'b1; v_i = 1'b0; s_i = '0; d_i = '0;
            slot = 0; pk[0] = 1'b0; pk[1] = 1'b0;
            do_reset("R7");
            for (int i = 0; i < 40 * C; i++)
                step(0, 16'(i * 40503 + g * 257) ^ 16'(slot * 965), "R1");
            for (int i = 0; i < 2 * C; i++)
                step((i == 0) ? 0 : 1, 16'h0123, "R6");
            for (int i = 0; i < 12 * C; i++)
                step(0, 16'h1111 * 16'(slot + 1), "R2");
            for (int i = 0; i < 60 * C; i++)
                step(((i % 7) == 2 || (i % 5) == 0) ? 1 : 0, 16'(i * 7919), "R4");
            for (int i = 0; i < 20 * C; i++)
                step(((i % 2) == 0) ? 2 : 0, 16'(i * 31 + 5), "R5");
            for (int i = 0; i < 8 * C; i++)
                step(0, 16'hFFFF, "R8");
            step(0, 16'h0001, "R8");
            do_reset("R7");
            for (int i = 0; i < 6 * C; i++)
                step(0, 16'(i + 1), "R7");
            for (int i = 0; i < 3; i++)
                step(1, 16'h0000, "R4");
            done[g] = 1'b1;
        end
    end

    initial begin
        wait (done == 4'hF);
        if (!closed) begin
            closed = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!closed) begin
            closed = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule